// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of up to fifteen nodes on a shared multi-drop bus may drive it next. Each node has a request line and a flag that marks its request as high priority. Any high-priority request wins over every standard one. Inside each of the two levels, ownership rotates. Each level keeps its own rotation pointer, which moves to the position just after that level's most recent winner.

A grant is one-hot and stays with its owner until the owner pulses the release input. The clock edge that samples the release also carries out the next arbitration, so the bus passes to the next owner in a single cycle. When no node is requesting, no grant is driven.

An optional fair mode groups grants into rounds. A node that has won in the current round is held back while any requesting node has not yet won in that round. Once every requesting node has been served, or has dropped its request, the round starts over.

Top module: `dual_tier_rr_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant_o` is all zeros, and both rotation pointers start at node 0.
- R2: An arbitration that finds no request drives `grant_o` to all zeros. An arbitration takes place on any clock edge where `grant_o` is zero or `release_i` is high. A release pulse with no request pending leaves `grant_o` at zero.
- R3: `grant_o` has at most one bit set. A new grant goes to a node whose `req_i` bit was high at the arbitration edge. From idle, the grant appears one clock after the request is first sampled.
- R4: While `release_i` is low and `grant_o` is nonzero, `grant_o` does not change, even if the requests change or the owner drops its request.
- R5: A release sampled while requests are pending hands the grant to the next winner on that same clock edge, with no idle cycle between owners.
- R6: When fair mode is off and any eligible node has `prio_hi_i` high, a node with `prio_hi_i` high wins the arbitration.
- R7: Within a level, the search starts at that level's pointer and goes upward, wrapping from node NODES-1 to node 0. The winning level's pointer moves to the winner's index plus one, modulo NODES. The other level's pointer does not move.
- R8: With `fair_en` high, a node granted in the current round cannot win again while some requesting node has not yet won in that round. The round restarts when every requesting node has won in it, which includes the case where the unserved nodes have withdrawn their requests.
- R9: With `fair_en` low, there is no round masking. A lone high-priority requester wins every arbitration over standard requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fair_en | input | 1 | Enables round-based fairness masking |
| req_i | input | NODES | Request line per node |
| prio_hi_i | input | NODES | High-priority flag per node, meaningful while its request is high |
| release_i | input | 1 | Pulsed by the current owner to give up the bus |
| grant_o | output | NODES | One-hot bus grant, zero when idle |

## Verification
Rotation is tried with all fifteen nodes requesting at standard level and a release on every grant. This shows whether the search wraps correctly and whether the pointer moves past the winner. A mixed set of high- and standard-priority requesters separates level precedence from rotation. When the high-priority requests are then removed, the first standard winner shows that the standard pointer did not move during the high-priority grants. One high-priority node against one standard node is run twice, with fair mode off and then on. Fair mode off must starve the standard node, and fair mode on must alternate the two. A final step withdraws the waiting node's request to confirm that the round restarts. Requests that change while a grant is held, and releases with nothing pending, check that the grant is held and that the arbiter goes idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {LVL_STD = 1'b0, LVL_HIGH = 1'b1} arb_level_e;
  localparam int NUM_LEVELS = 2;

  function automatic int wrap_idx(input int raw, input int n);
    return (raw >= n) ? raw - n : raw;
  endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  import arb_pkg::*;

  // Search upward from ptr with wrap; first set bit wins.
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && vec[wrap_idx(int'(ptr) + k, N)]) begin
        found = 1'b1;
        idx   = IW'(wrap_idx(int'(ptr) + k, N));
        onehot[wrap_idx(int'(ptr) + k, N)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_fair_round.sv
module arb_fair_round #(
  parameter int N = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fair_en,
  input  logic [N-1:0] req,
  input  logic         take,
  input  logic [N-1:0] win,
  output logic [N-1:0] eligible
);
  logic [N-1:0] served_q;
  logic [N-1:0] pending;
  logic         restart;

  assign pending  = req & ~served_q;
  assign restart  = (pending == '0);
  assign eligible = (fair_en && !restart) ? pending : req;

  always_ff @(posedge clk) begin
    if (!rst_n || !fair_en) begin
      served_q <= '0;
    end else if (take) begin
      served_q <= (restart ? '0 : served_q) | win;
    end
  end
endmodule

// File: rtl/dual_tier_rr_arbiter.sv
module dual_tier_rr_arbiter #(
  parameter int NODES = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fair_en,
  input  logic [NODES-1:0] req_i,
  input  logic [NODES-1:0] prio_hi_i,
  input  logic             release_i,
  output logic [NODES-1:0] grant_o
);
  import arb_pkg::*;

  localparam int IW = (NODES > 1) ? $clog2(NODES) : 1;

  logic [NODES-1:0] grant_q;
  logic [NODES-1:0] eligible;
  logic [NODES-1:0] lvl_vec  [NUM_LEVELS];
  logic [NODES-1:0] lvl_oh   [NUM_LEVELS];
  logic [IW-1:0]    lvl_idx  [NUM_LEVELS];
  logic [IW-1:0]    ptr_q    [NUM_LEVELS];
  logic             lvl_found[NUM_LEVELS];
  logic             arb_en;
  logic             hi_wins;
  logic [NODES-1:0] win_oh;

  assign arb_en = (grant_q == '0) || release_i;

  arb_fair_round #(.N(NODES)) u_fair (
    .clk      (clk),
    .rst_n    (rst_n),
    .fair_en  (fair_en),
    .req      (req_i),
    .take     (arb_en && (win_oh != '0)),
    .win      (win_oh),
    .eligible (eligible)
  );

  for (genvar gl = 0; gl < NUM_LEVELS; gl++) begin : g_lvl
    if (gl == int'(LVL_HIGH)) begin : g_hi
      assign lvl_vec[gl] = eligible & prio_hi_i;
    end else begin : g_std
      assign lvl_vec[gl] = eligible & ~prio_hi_i;
    end
    arb_rr_pick #(.N(NODES), .IW(IW)) u_pick (
      .vec    (lvl_vec[gl]),
      .ptr    (ptr_q[gl]),
      .found  (lvl_found[gl]),
      .idx    (lvl_idx[gl]),
      .onehot (lvl_oh[gl])
    );
  end

  assign hi_wins = lvl_found[LVL_HIGH];
  assign win_oh  = hi_wins ? lvl_oh[LVL_HIGH] : lvl_oh[LVL_STD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      for (int l = 0; l < NUM_LEVELS; l++) ptr_q[l] <= '0;
    end else if (arb_en) begin
      grant_q <= win_oh;
      for (int l = 0; l < NUM_LEVELS; l++) begin
        if (lvl_found[l] && ((l == int'(LVL_HIGH)) || !hi_wins)) begin
          ptr_q[l] <= IW'(wrap_idx(int'(lvl_idx[l]) + 1, NODES));
        end
      end
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N = 15
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fair_en,
  input logic [N-1:0] req_i,
  input logic [N-1:0] prio_hi_i,
  input logic         release_i,
  input logic [N-1:0] grant_o
);
  logic arb_edge;
  assign arb_edge = (grant_o == '0) || release_i;

  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_edge && req_i != '0) |=> ((grant_o & $past(req_i)) != '0));

  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_edge && req_i == '0) |=> (grant_o == '0));

  assert_hold_until_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !release_i) |=> $stable(grant_o));

  assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && release_i && req_i != '0) |=> (grant_o != '0));

  assert_high_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_edge && !fair_en && (req_i & prio_hi_i) != '0)
      |=> ((grant_o & $past(req_i & prio_hi_i)) != '0));
endmodule

bind dual_tier_rr_arbiter arb_checker #(.N(NODES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fair_en   (fair_en),
  .req_i     (req_i),
  .prio_hi_i (prio_hi_i),
  .release_i (release_i),
  .grant_o   (grant_o)
);

// File: tb/dual_tier_rr_arbiter_tb.sv
`timescale 1ns/1ps
module dual_tier_rr_arbiter_tb;
  localparam int N = 15;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fair_en = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] prio_hi_i = '0;
  logic         release_i = 1'b0;
  logic [N-1:0] grant_o;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  dual_tier_rr_arbiter #(.NODES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .fair_en(fair_en), .req_i(req_i),
    .prio_hi_i(prio_hi_i), .release_i(release_i), .grant_o(grant_o)
  );

  // Behavioural reference model
  int m_gnt;
  int m_ptr [2];
  bit m_served [N];

  always @(posedge clk) begin
    int pend, win, wl, j;
    bit elig [N];
    if (!rst_n) begin
      m_gnt = -1;
      m_ptr[0] = 0; m_ptr[1] = 0;
      foreach (m_served[i]) m_served[i] = 0;
    end else begin
      if (m_gnt < 0 || release_i) begin
        pend = 0;
        for (int i = 0; i < N; i++) if (req_i[i] && !m_served[i]) pend++;
        for (int i = 0; i < N; i++)
          elig[i] = (fair_en && pend > 0) ? (req_i[i] && !m_served[i]) : req_i[i];
        win = -1; wl = 0;
        for (int lv = 1; lv >= 0; lv--) begin
          for (int k = 0; k < N; k++) begin
            j = (m_ptr[lv] + k) % N;
            if (win < 0 && elig[j] && (int'(prio_hi_i[j]) == lv)) begin
              win = j; wl = lv;
            end
          end
        end
        m_gnt = win;
        if (win >= 0) begin
          m_ptr[wl] = (win + 1) % N;
          if (fair_en) begin
            if (pend == 0) foreach (m_served[i]) m_served[i] = 0;
            m_served[win] = 1;
          end
        end
      end
      if (!fair_en) foreach (m_served[i]) m_served[i] = 0;
    end
  end

  function automatic logic [N-1:0] node(input int n);
    return (n < 0) ? '0 : (N'(1) << n);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) chk({cur_tag, " model"}, grant_o, node(m_gnt));
  end

  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; prio_hi_i = '0; release_i = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_release();
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", grant_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", grant_o, '0);

    cur_tag = "R2";
    repeat (3) @(negedge clk);
    chk("R2 no requests", grant_o, '0);
    pulse_release();
    chk("R2 release while idle", grant_o, '0);

    cur_tag = "R3";
    req_i = node(3);
    @(negedge clk);
    chk("R3 single requester", grant_o, node(3));
    cur_tag = "R4";
    req_i = node(5) | node(9);
    repeat (3) @(negedge clk);
    chk("R4 hold while others request", grant_o, node(3));
    req_i = node(5);
    cur_tag = "R5";
    pulse_release();
    chk("R5 handover in one clock", grant_o, node(5));
    req_i = '0;
    pulse_release();
    chk("R2 release to idle", grant_o, '0);

    cur_tag = "R7";
    do_reset();
    req_i = '1;
    @(negedge clk);
    chk("R7 first from pointer 0", grant_o, node(0));
    for (int i = 1; i <= 16; i++) begin
      pulse_release();
      chk("R7 rotation with wrap", grant_o, node(i % N));
    end

    cur_tag = "R6";
    do_reset();
    req_i = '1;
    prio_hi_i = node(4) | node(9);
    @(negedge clk);
    chk("R6 high beats standard", grant_o, node(4));
    pulse_release();
    chk("R6 high level rotates", grant_o, node(9));
    pulse_release();
    chk("R6 high level wraps", grant_o, node(4));
    prio_hi_i = '0;
    cur_tag = "R7";
    pulse_release();
    chk("R7 standard pointer untouched", grant_o, node(0));
    pulse_release();
    chk("R7 standard pointer advances", grant_o, node(1));

    cur_tag = "R9";
    do_reset();
    req_i = node(2) | node(7);
    prio_hi_i = node(2);
    @(negedge clk);
    chk("R9 high node first", grant_o, node(2));
    for (int i = 0; i < 3; i++) begin
      pulse_release();
      chk("R9 no fairness, high keeps winning", grant_o, node(2));
    end

    cur_tag = "R8";
    do_reset();
    fair_en = 1'b1;
    req_i = node(2) | node(7);
    prio_hi_i = node(2);
    @(negedge clk);
    chk("R8 round start", grant_o, node(2));
    pulse_release();
    chk("R8 served high node masked", grant_o, node(7));
    pulse_release();
    chk("R8 new round", grant_o, node(2));
    req_i = node(2);
    pulse_release();
    chk("R8 waiting node withdrew", grant_o, node(2));
    req_i = node(2) | node(7);
    pulse_release();
    chk("R8 masked after regrant", grant_o, node(7));
    req_i = '0;
    pulse_release();
    chk("R2 idle in fair mode", grant_o, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule